// File: doc/BRIEF.md
# Sixteen-Channel GPIO Matrix Mapper

This block services one frame of a sixteen-channel general-purpose I/O matrix at a time. Each frame brings a single 32-bit control word. The low half gives each logical channel its direction and the high half gives its output level. The sixteen channels are spread over two 32-bit GPIO banks through a fixed, irregular pin map. For every frame the block updates both banks' output-enable registers with a read-modify-write. It then samples both banks' input registers and issues a clear-mask write followed by a set-mask write to each bank. It hands back the control word with the sampled level of every input channel written into that channel's level bit.

A frame starts with a one-cycle `start` while the block is idle, which captures `word_in`. Every bank access uses a simple register port. The block drives enable, write, a 2-bit register select and write data. It takes the read data on the cycle after a read request. `done` pulses for one cycle when `word_out` holds the finished word. A `start` that arrives during a frame has no effect.

Top module: `gpio_matrix_mapper`

## Requirements
- R1: For an output channel (word bit ch = 0), the channel's bank output-enable bit is written 0. Its pin bit appears in the set mask when word bit ch+16 is 1, and in the clear mask when it is 0.
- R2: For an input channel (word bit ch = 1), the channel's bank output-enable bit is written 1. Its pin bit appears in neither the set mask nor the clear mask.
- R3: Channel ch maps to a bank and a pin as follows. Channels 0, 1, 2 and 3 use bank 2 pins 2, 3, 5 and 4. Channels 4 to 10 use bank 1 pins 13, 12, 28, 18, 15, 14 and 19. Channels 11 to 15 use bank 2 pins 1, 22, 24, 23 and 25. Masks hold no bits other than mapped pins.
- R4: Each bank's output-enable value is read from register select 0 and written back to select 0. Every unmapped bit keeps the value that was read.
- R5: In `word_out`, bit ch+16 of every input channel equals the sampled input level of its pin, read from register select 1. Every other bit equals `word_in` as captured at start.
- R6: Accesses occur in a fixed order. Bank 1 output-enable is written first and bank 2 output-enable after it. Both input registers are read after both output-enable writes. Then the clear mask (select 2) is written in the cycle directly before the set mask (select 3).
- R7: `done` is high for exactly one cycle, 7 cycles after the cycle in which `start` was accepted. `word_out` is valid in that cycle and stays unchanged until the next frame is captured.
- R8: A `start` raised while a frame is in progress is ignored: no extra accesses are made, no extra `done` occurs, and the word is not replaced.
- R9: After reset the block is idle. `done` is 0, `word_out` is 0, and neither bank port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| word_in | input | 32 | Control word: [15:0] direction (1 = input), [31:16] level |
| done | output | 1 | One-cycle pulse, word_out valid |
| word_out | output | 32 | Control word with input levels filled in |
| b1_en | output | 1 | Bank 1 access enable |
| b1_wr | output | 1 | Bank 1 write (1) or read (0) |
| b1_sel | output | 2 | Bank 1 register: 0 OE, 1 input, 2 clear, 3 set |
| b1_wdata | output | 32 | Bank 1 write data |
| b1_rdata | input | 32 | Bank 1 read data, valid the cycle after a read |
| b2_en | output | 1 | Bank 2 access enable |
| b2_wr | output | 1 | Bank 2 write (1) or read (0) |
| b2_sel | output | 2 | Bank 2 register: 0 OE, 1 input, 2 clear, 3 set |
| b2_wdata | output | 32 | Bank 2 write data |
| b2_rdata | input | 32 | Bank 2 read data, valid the cycle after a read |

## Verification
Counting from the clock edge that accepts `start`, the bank accesses follow at fixed offsets. The bank 1 output-enable read comes at +1 and its write at +2. Bank 2's read and write come at +3 and +4. The input read comes at +5, the clear write at +6 and the set write at +7, and `done` is high in the cycle after the clear write. The bench drives and samples on falling edges. It counts falling edges from the one where `start` was driven and expects `done` on the seventh. It compares the word there, then waits one more edge so that the set write has landed before it checks the bank model registers. Ordering is checked from edge stamps recorded by the bank models rather than from absolute times, and the latency check pins down the offset.

// File: rtl/gmm_pkg.sv
package gmm_pkg;
  localparam int NCH   = 16;
  localparam int BW    = 32;
  localparam int WW    = 2 * NCH;
  localparam int NBANK = 2;
  localparam int SELW  = 2;

  typedef enum logic [SELW-1:0] {
    SEL_OE  = 2'd0,
    SEL_IN  = 2'd1,
    SEL_CLR = 2'd2,
    SEL_SET = 2'd3
  } bank_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_OE1 = 3'd1,
    ST_WR_OE1 = 3'd2,
    ST_RD_OE2 = 3'd3,
    ST_WR_OE2 = 3'd4,
    ST_RD_IN  = 3'd5,
    ST_CAP    = 3'd6,
    ST_SET    = 3'd7
  } seq_st_e;

  // Bank number (1 or 2) of a logical channel.
  function automatic int ch_bank(int ch);
    return (ch >= 4 && ch <= 10) ? 1 : 2;
  endfunction

  // Pin index inside its bank of a logical channel.
  function automatic int ch_pin(int ch);
    case (ch)
      0:  return 2;
      1:  return 3;
      2:  return 5;
      3:  return 4;
      4:  return 13;
      5:  return 12;
      6:  return 28;
      7:  return 18;
      8:  return 15;
      9:  return 14;
      10: return 19;
      11: return 1;
      12: return 22;
      13: return 24;
      14: return 23;
      15: return 25;
      default: return 0;
    endcase
  endfunction

  // All pins of a bank that some channel drives.
  function automatic logic [BW-1:0] bank_map(int bank);
    logic [BW-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_bank(c) == bank) m[ch_pin(c)] = 1'b1;
    return m;
  endfunction

  // New output-enable value: mapped bits follow direction, rest kept.
  function automatic logic [BW-1:0] oe_merge(logic [WW-1:0] w, logic [BW-1:0] cur, int bank);
    logic [BW-1:0] r;
    r = cur;
    for (int c = 0; c < NCH; c++)
      if (ch_bank(c) == bank) r[ch_pin(c)] = w[c];
    return r;
  endfunction

  // Pins to drive high (output channels with level 1).
  function automatic logic [BW-1:0] set_mask(logic [WW-1:0] w, int bank);
    logic [BW-1:0] r;
    r = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_bank(c) == bank && !w[c] && w[c+NCH]) r[ch_pin(c)] = 1'b1;
    return r;
  endfunction

  // Pins to drive low (output channels with level 0).
  function automatic logic [BW-1:0] clr_mask(logic [WW-1:0] w, int bank);
    logic [BW-1:0] r;
    r = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_bank(c) == bank && !w[c] && !w[c+NCH]) r[ch_pin(c)] = 1'b1;
    return r;
  endfunction

  // Copy sampled pin levels into the level bits of input channels.
  function automatic logic [WW-1:0] readback(logic [WW-1:0] w, logic [BW-1:0] in1,
                                             logic [BW-1:0] in2);
    logic [WW-1:0] r;
    r = w;
    for (int c = 0; c < NCH; c++)
      if (w[c]) r[c+NCH] = (ch_bank(c) == 1) ? in1[ch_pin(c)] : in2[ch_pin(c)];
    return r;
  endfunction
endpackage

// File: rtl/gmm_bank_masks.sv
module gmm_bank_masks
  import gmm_pkg::*;
#(
  parameter int BANK = 1
) (
  input  logic [WW-1:0] word,
  input  logic [BW-1:0] cur_oe,
  output logic [BW-1:0] oe_next,
  output logic [BW-1:0] set_m,
  output logic [BW-1:0] clr_m
);
  always_comb begin
    oe_next = oe_merge(word, cur_oe, BANK);
    set_m   = set_mask(word, BANK);
    clr_m   = clr_mask(word, BANK);
  end
endmodule

// File: rtl/gmm_readback.sv
module gmm_readback
  import gmm_pkg::*;
(
  input  logic [WW-1:0] word,
  input  logic [BW-1:0] in1,
  input  logic [BW-1:0] in2,
  output logic [WW-1:0] word_next
);
  always_comb word_next = readback(word, in1, in2);
endmodule

// File: rtl/gmm_seq.sv
module gmm_seq
  import gmm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output seq_st_e state,
  output logic    busy,
  output logic    load
);
  seq_st_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = ST_RD_OE1;
      ST_RD_OE1: nxt = ST_WR_OE1;
      ST_WR_OE1: nxt = ST_RD_OE2;
      ST_RD_OE2: nxt = ST_WR_OE2;
      ST_WR_OE2: nxt = ST_RD_IN;
      ST_RD_IN:  nxt = ST_CAP;
      ST_CAP:    nxt = ST_SET;
      ST_SET:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign busy = (state != ST_IDLE);
  assign load = !busy && start;
endmodule

// File: rtl/gpio_matrix_mapper.sv
module gpio_matrix_mapper
  import gmm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WW-1:0]   word_in,
  output logic            done,
  output logic [WW-1:0]   word_out,
  output logic            b1_en,
  output logic            b1_wr,
  output logic [SELW-1:0] b1_sel,
  output logic [BW-1:0]   b1_wdata,
  input  logic [BW-1:0]   b1_rdata,
  output logic            b2_en,
  output logic            b2_wr,
  output logic [SELW-1:0] b2_sel,
  output logic [BW-1:0]   b2_wdata,
  input  logic [BW-1:0]   b2_rdata
);
  seq_st_e       state;
  logic          busy;
  logic          load;
  logic [WW-1:0] word_q;
  logic [WW-1:0] word_rb;

  logic [BW-1:0]   rdata   [NBANK];
  logic [BW-1:0]   oe_next [NBANK];
  logic [BW-1:0]   set_m   [NBANK];
  logic [BW-1:0]   clr_m   [NBANK];
  logic            en      [NBANK];
  logic            wr      [NBANK];
  logic [SELW-1:0] sel     [NBANK];
  logic [BW-1:0]   wdata   [NBANK];

  // Named events for the checker.
  logic ev_oe1_wr, ev_oe2_wr, ev_in_rd, ev_clr_wr, ev_set_wr;

  gmm_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .state (state),
    .busy  (busy),
    .load  (load)
  );

  assign rdata[0] = b1_rdata;
  assign rdata[1] = b2_rdata;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    gmm_bank_masks #(.BANK(g + 1)) u_masks (
      .word    (word_q),
      .cur_oe  (rdata[g]),
      .oe_next (oe_next[g]),
      .set_m   (set_m[g]),
      .clr_m   (clr_m[g])
    );

    localparam seq_st_e RD_OE = (g == 0) ? ST_RD_OE1 : ST_RD_OE2;
    localparam seq_st_e WR_OE = (g == 0) ? ST_WR_OE1 : ST_WR_OE2;

    always_comb begin
      en[g]    = 1'b0;
      wr[g]    = 1'b0;
      sel[g]   = SEL_OE;
      wdata[g] = '0;
      if (state == RD_OE) begin
        en[g] = 1'b1;
      end else if (state == WR_OE) begin
        en[g]    = 1'b1;
        wr[g]    = 1'b1;
        wdata[g] = oe_next[g];
      end else if (state == ST_RD_IN) begin
        en[g]  = 1'b1;
        sel[g] = SEL_IN;
      end else if (state == ST_CAP) begin
        en[g]    = 1'b1;
        wr[g]    = 1'b1;
        sel[g]   = SEL_CLR;
        wdata[g] = clr_m[g];
      end else if (state == ST_SET) begin
        en[g]    = 1'b1;
        wr[g]    = 1'b1;
        sel[g]   = SEL_SET;
        wdata[g] = set_m[g];
      end
    end
  end

  gmm_readback u_rb (
    .word      (word_q),
    .in1       (b1_rdata),
    .in2       (b2_rdata),
    .word_next (word_rb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 word_q <= '0;
    else if (load)              word_q <= word_in;
    else if (state == ST_CAP)   word_q <= word_rb;
  end

  assign word_out = word_q;
  assign done     = (state == ST_SET);

  assign b1_en    = en[0];
  assign b1_wr    = wr[0];
  assign b1_sel   = sel[0];
  assign b1_wdata = wdata[0];
  assign b2_en    = en[1];
  assign b2_wr    = wr[1];
  assign b2_sel   = sel[1];
  assign b2_wdata = wdata[1];

  assign ev_oe1_wr = b1_en && b1_wr && (b1_sel == SEL_OE);
  assign ev_oe2_wr = b2_en && b2_wr && (b2_sel == SEL_OE);
  assign ev_in_rd  = b1_en && !b1_wr && (b1_sel == SEL_IN);
  assign ev_clr_wr = b1_en && b1_wr && (b1_sel == SEL_CLR);
  assign ev_set_wr = b1_en && b1_wr && (b1_sel == SEL_SET);
endmodule

// File: rtl/gmm_checker.sv
module gmm_checker
  import gmm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            done,
  input logic            busy,
  input logic            ev_oe1_wr,
  input logic            ev_oe2_wr,
  input logic            ev_in_rd,
  input logic            ev_clr_wr,
  input logic            ev_set_wr,
  input logic            b1_en,
  input logic            b1_wr,
  input logic [SELW-1:0] b1_sel,
  input logic [BW-1:0]   b1_wdata,
  input logic [BW-1:0]   b1_rdata,
  input logic            b2_en,
  input logic            b2_wr,
  input logic [SELW-1:0] b2_sel,
  input logic [BW-1:0]   b2_wdata,
  input logic [BW-1:0]   b2_rdata
);
  localparam logic [BW-1:0] MAP1 = bank_map(1);
  localparam logic [BW-1:0] MAP2 = bank_map(2);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_OE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ev_oe2_wr |-> $past(ev_oe1_wr, 2)); // R6
  AST_IN_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in_rd |-> $past(ev_oe2_wr)); // R6
  AST_SET_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set_wr |-> $past(ev_clr_wr)); // R6
  AST_KEEP_UNMAPPED1: assert property (@(posedge clk) disable iff (!rst_n)
    (b1_en && b1_wr && b1_sel == SEL_OE) |-> (((b1_wdata ^ b1_rdata) & ~MAP1) == '0)); // R4
  AST_KEEP_UNMAPPED2: assert property (@(posedge clk) disable iff (!rst_n)
    (b2_en && b2_wr && b2_sel == SEL_OE) |-> (((b2_wdata ^ b2_rdata) & ~MAP2) == '0)); // R4
  AST_MASKS_MAPPED1: assert property (@(posedge clk) disable iff (!rst_n)
    (b1_en && b1_wr && b1_sel[1]) |-> ((b1_wdata & ~MAP1) == '0)); // R3
  AST_MASKS_MAPPED2: assert property (@(posedge clk) disable iff (!rst_n)
    (b2_en && b2_wr && b2_sel[1]) |-> ((b2_wdata & ~MAP2) == '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!b1_en && !b2_en)); // R9
  AST_BUSY_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy); // R8
endmodule

bind gpio_matrix_mapper gmm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .busy      (busy),
  .ev_oe1_wr (ev_oe1_wr),
  .ev_oe2_wr (ev_oe2_wr),
  .ev_in_rd  (ev_in_rd),
  .ev_clr_wr (ev_clr_wr),
  .ev_set_wr (ev_set_wr),
  .b1_en     (b1_en),
  .b1_wr     (b1_wr),
  .b1_sel    (b1_sel),
  .b1_wdata  (b1_wdata),
  .b1_rdata  (b1_rdata),
  .b2_en     (b2_en),
  .b2_wr     (b2_wr),
  .b2_sel    (b2_sel),
  .b2_wdata  (b2_wdata),
  .b2_rdata  (b2_rdata)
);

// File: tb/sim_gpio_matrix_mapper.sv
`timescale 1ns/1ps

module sim_bank (
  input  logic        clk,
  input  logic [31:0] cyc,
  input  logic        en,
  input  logic        wr,
  input  logic [1:0]  sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] din,
  input  logic        pre_en,
  input  logic [31:0] pre_val,
  output logic [31:0] oe,
  output logic [31:0] last_clr,
  output logic [31:0] last_set,
  output logic [31:0] t_oe,
  output logic [31:0] t_in,
  output logic [31:0] t_clr,
  output logic [31:0] t_set,
  output logic [31:0] n_oe
);
  initial begin
    rdata = 0; oe = 0; last_clr = 0; last_set = 0;
    t_oe = 0; t_in = 0; t_clr = 0; t_set = 0; n_oe = 0;
  end
  always_ff @(posedge clk) begin
    if (pre_en) oe <= pre_val;
    if (en && wr) begin
      case (sel)
        2'd0: begin oe <= wdata; t_oe <= cyc; n_oe <= n_oe + 1; end
        2'd2: begin last_clr <= wdata; t_clr <= cyc; end
        2'd3: begin last_set <= wdata; t_set <= cyc; end
        default: ;
      endcase
    end else if (en) begin
      rdata <= (sel == 2'd1) ? din : oe;
      if (sel == 2'd1) t_in <= cyc;
    end
  end
endmodule

module sim_gpio_matrix_mapper;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [31:0] word_in = 0;
  logic done;
  logic [31:0] word_out;
  logic b1_en, b1_wr, b2_en, b2_wr;
  logic [1:0] b1_sel, b2_sel;
  logic [31:0] b1_wdata, b1_rdata, b2_wdata, b2_rdata;
  logic [31:0] cyc = 0;
  logic [31:0] din1 = 0, din2 = 0, pv1 = 0, pv2 = 0;
  logic pre_en = 0;
  logic [31:0] oe1, oe2, clr1, clr2, set1, set2;
  logic [31:0] toe1, toe2, tin1, tin2, tclr1, tclr2, tset1, tset2, noe1, noe2;

  int checks = 0;
  int errors = 0;
  int bank_of [16];
  int pin_of  [16];
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_matrix_mapper u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
    .done(done), .word_out(word_out),
    .b1_en(b1_en), .b1_wr(b1_wr), .b1_sel(b1_sel), .b1_wdata(b1_wdata), .b1_rdata(b1_rdata),
    .b2_en(b2_en), .b2_wr(b2_wr), .b2_sel(b2_sel), .b2_wdata(b2_wdata), .b2_rdata(b2_rdata)
  );

  sim_bank m1 (.clk(clk), .cyc(cyc), .en(b1_en), .wr(b1_wr), .sel(b1_sel), .wdata(b1_wdata),
    .rdata(b1_rdata), .din(din1), .pre_en(pre_en), .pre_val(pv1), .oe(oe1), .last_clr(clr1),
    .last_set(set1), .t_oe(toe1), .t_in(tin1), .t_clr(tclr1), .t_set(tset1), .n_oe(noe1));
  sim_bank m2 (.clk(clk), .cyc(cyc), .en(b2_en), .wr(b2_wr), .sel(b2_sel), .wdata(b2_wdata),
    .rdata(b2_rdata), .din(din2), .pre_en(pre_en), .pre_val(pv2), .oe(oe2), .last_clr(clr2),
    .last_set(set2), .t_oe(toe2), .t_in(tin2), .t_clr(tclr2), .t_set(tset2), .n_oe(noe2));

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_oe(int bank, logic [31:0] pre, logic [31:0] w);
    logic [31:0] r = pre;
    for (int c = 0; c < 16; c++) if (bank_of[c] == bank) r[pin_of[c]] = w[c];
    return r;
  endfunction
  function automatic logic [31:0] e_mask(int bank, logic [31:0] w, bit lvl);
    logic [31:0] r = 0;
    for (int c = 0; c < 16; c++)
      if (bank_of[c] == bank && !w[c] && w[c+16] == lvl) r[pin_of[c]] = 1'b1;
    return r;
  endfunction
  function automatic logic [31:0] e_word(logic [31:0] w, logic [31:0] i1, logic [31:0] i2);
    logic [31:0] r = w;
    for (int c = 0; c < 16; c++)
      if (w[c]) r[c+16] = (bank_of[c] == 1) ? i1[pin_of[c]] : i2[pin_of[c]];
    return r;
  endfunction

  // One frame; if intr is set, a second start with another word is driven mid-frame.
  task automatic frame(input logic [31:0] w, input bit intr, input string mtag);
    logic [31:0] p1, p2, i1, i2, ew, n1;
    int n, ndone, tdone;
    p1 = rnd(); p2 = rnd(); i1 = rnd(); i2 = rnd();
    @(negedge clk); pv1 = p1; pv2 = p2; pre_en = 1;
    @(negedge clk); pre_en = 0; din1 = i1; din2 = i2;
    n1 = noe1;
    ew = e_word(w, i1, i2);
    start = 1; word_in = w;
    n = 0; ndone = 0; tdone = 0;
    while (n < 12) begin
      @(negedge clk); n++;
      start = 0;
      if (intr && n == 3) begin start = 1; word_in = ~w; end
      if (done) begin
        ndone++; tdone = n;
        chk(word_out == ew, "R5 word_out", word_out, ew);
      end
      if (n == 8) begin
        chk(done == 1'b0, "R7 done drops", {31'd0, done}, 32'd0);
        chk(word_out == ew, "R7 word held", word_out, ew);
        chk(oe1 == e_oe(1, p1, w), "R1 R2 R4 bank1 OE", oe1, e_oe(1, p1, w));
        chk(oe2 == e_oe(2, p2, w), "R1 R2 R4 bank2 OE", oe2, e_oe(2, p2, w));
        chk(set1 == e_mask(1, w, 1'b1), {mtag, " bank1 set"}, set1, e_mask(1, w, 1'b1));
        chk(clr1 == e_mask(1, w, 1'b0), {mtag, " bank1 clr"}, clr1, e_mask(1, w, 1'b0));
        chk(set2 == e_mask(2, w, 1'b1), {mtag, " bank2 set"}, set2, e_mask(2, w, 1'b1));
        chk(clr2 == e_mask(2, w, 1'b0), {mtag, " bank2 clr"}, clr2, e_mask(2, w, 1'b0));
        chk(toe1 < toe2 && toe2 < tin1 && tin1 == tin2 && tin1 < tclr1,
            "R6 OE1<OE2<IN<CLR", toe2, toe1);
        chk(tset1 == tclr1 + 1 && tset2 == tclr2 + 1 && tclr1 == tclr2,
            "R6 clr then set", tset1, tclr1 + 1);
      end
    end
    chk(tdone == 7, "R7 done latency", tdone, 7);
    chk(ndone == 1, intr ? "R8 single done" : "R7 single done", ndone, 1);
    if (intr) chk(noe1 == n1 + 1, "R8 no extra OE write", noe1, n1 + 1);
  endtask

  initial begin
    bank_of = '{2, 2, 2, 2, 1, 1, 1, 1, 1, 1, 1, 2, 2, 2, 2, 2};
    pin_of  = '{2, 3, 5, 4, 13, 12, 28, 18, 15, 14, 19, 1, 22, 24, 23, 25};
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9 reset done", {31'd0, done}, 0);
    chk(word_out == 0, "R9 reset word", word_out, 0);
    chk(!b1_en && !b2_en, "R9 reset ports idle", {30'd0, b1_en, b2_en}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!b1_en && !b2_en, "R9 idle after reset", {30'd0, b1_en, b2_en}, 0);
    // Walk each channel as sole output, high then low, others inputs.
    for (int c = 0; c < 16; c++) begin
      frame({16'(1 << c), ~16'(1 << c)}, 1'b0, "R3 walk-high");
      frame({16'h0000, ~16'(1 << c)}, 1'b0, "R3 walk-low");
    end
    // Walk each channel as sole input, outputs with random levels.
    for (int c = 0; c < 16; c++) begin
      logic [31:0] r = rnd();
      frame({r[31:16], 16'(1 << c)}, 1'b0, "R2 walk-input");
    end
    frame(32'h0000_FFFF, 1'b0, "R2 all-input");
    frame(32'hFFFF_FFFF, 1'b0, "R2 all-input-hi");
    frame(32'hFFFF_0000, 1'b0, "R1 all-high");
    frame(32'h0000_0000, 1'b0, "R1 all-low");
    for (int k = 0; k < 40; k++) frame(rnd(), 1'b0, "R1 R2 mixed");
    for (int k = 0; k < 4; k++) frame(rnd(), 1'b1, "R8 busy-start");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule